// File: doc/BRIEF.md
# Step-Sequenced Trigger Unit

The block watches a 16-bit vector of sense signals and walks through a programmable sequence of up to eight steps, in the manner of a logic analyser's trigger engine. In the active step, four pattern groups compare the sense vector against a masked value. Each group also carries a qualifier that looks at a shared event counter and a dwell timer. When several groups are satisfied, the highest-numbered group wins. Its action word then decides what happens: jump to another step, pulse trigger lines, raise the sticky interrupt, and change the counter or timer.

Software fills the configuration through a single-cycle write port while the unit is disabled, or on the fly. A clear input wipes every setting back to zero, and a zero setting never fires. Raising the enable starts the sequence at step 0 with the counter and timer at zero. A typical use is to arm a chain such as "pattern A, then pattern B within N cycles, then B seen three times" and route the resulting trigger pulse to a cross-trigger network or a processor.

Top module: `tgu_trigger_unit`

## Requirements
- R1: After reset, and on every cycle that follows a cycle with enable low, the unit is in step 0, the counter and timer are zero and all trigger outputs are low.
- R2: A group matches when `((sense ^ value) & mask) == 0` on the current cycle. Sense and value bits outside the mask have no effect. A group word holds the mask in bits [31:16] and the value in bits [15:0].
- R3: When more than one group of the active step is satisfied, only the action of the highest-numbered group (3 highest, 0 lowest) is taken in that cycle.
- R4: A group acts only if its action word has bit [15] (arm) set. The other fields of an action word are: [14] use-pattern, [13:12] qualifier, [11] timer clear, [10:9] counter op, [8] interrupt, [7:4] trigger lines, [3] jump, [2:0] next step.
- R5: A satisfied group with the jump bit set makes its next-step field the active step from the following clock edge. Without the jump bit, the step is unchanged.
- R6: The trigger field of the acting group appears on the trigger outputs for exactly the cycle after the clock edge at which it acted. Cycles with no acting group leave the outputs at zero.
- R7: Counter ops are 0 hold, 1 increment, 2 decrement and 3 zero. The 16-bit counter saturates at 0 and at 0xFFFF. Qualifier 1 requires counter >= limit, and qualifier 3 requires counter < limit. Qualifier 0 adds no requirement.
- R8: The timer counts one per enabled cycle and saturates at 0xFFFF. It restarts at zero on every jump and on a timer-clear action. Qualifier 2 requires timer >= compare.
- R9: An acting group with the interrupt bit set sets the interrupt output. The interrupt then stays high, including while the unit is disabled, until a write to sub-address 15.
- R10: A one-cycle pulse on the configuration clear input returns every group word, action word, counter limit and timer compare to zero.
- R11: Write address = {step[2:0], sub[3:0]}. Sub-addresses 0..3 are group words, 4..7 are the action words of groups 0..3, and 8 holds {timer compare[31:16], counter limit[15:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the sequence idle at step 0 |
| cfg_clr_i | input | 1 | Synchronous clear of all configuration |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Write address {step, sub-address} |
| cfg_wdata_i | input | 32 | Write data |
| sense_i | input | 16 | Sensed signals |
| trig_o | output | 4 | Trigger pulses |
| irq_o | output | 1 | Sticky interrupt |

## Verification
The embedded properties check on every cycle that a disabled cycle leaves step, counter, timer and triggers idle. They also check that triggers only follow a cycle in which a group acted, that the step and counter hold when nothing acts, that the counter does not wrap below zero, that the interrupt is sticky until cleared, and that a clear empties the configuration. Only the bench scenarios can show the outcomes that need a programmed sequence. These are the masked compare on concrete patterns, the pick among several satisfied groups, a multi-step chain, the "seen three times" count and the timer expiry after a known dwell. The restart at step 0 after a disable is also shown this way.

// File: rtl/tgu_pkg.sv
// Shared sizes, encodings and configuration word layouts of the trigger unit.
// Assumes the data word is twice the sense width and the counter width
// equals the sense width, so group and limit words split into two halves.
package tgu_pkg;
    localparam int STEPS    = 8;
    localparam int GROUPS   = 4;
    localparam int SENSE_W  = 16;
    localparam int CNT_W    = SENSE_W;
    localparam int TRIG_W   = 4;
    localparam int DATA_W   = 2 * SENSE_W;
    localparam int STEP_W   = $clog2(STEPS);
    localparam int SEL_W    = 4;
    localparam int ADDR_W   = STEP_W + SEL_W;
    localparam int SEL_ACT0 = GROUPS;
    localparam int SEL_LIM  = 2 * GROUPS;
    localparam int SEL_IRQC = (1 << SEL_W) - 1;

    typedef enum logic [1:0] {
        Q_ALWAYS  = 2'd0,
        Q_CNT_GE  = 2'd1,
        Q_TMR_GE  = 2'd2,
        Q_CNT_LT  = 2'd3
    } qual_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_ZERO = 2'd3
    } cnt_op_e;

    // condition part of an action word
    typedef struct packed {
        logic  arm;
        logic  use_pat;
        qual_e qual;
    } cond_t;

    // effect part of an action word
    typedef struct packed {
        logic              tmr_clr;
        cnt_op_e           cnt_op;
        logic              irq;
        logic [TRIG_W-1:0] trig;
        logic              jump;
        logic [STEP_W-1:0] next;
    } do_t;

    typedef struct packed {
        cond_t c;
        do_t   d;
    } act_t;

    localparam int ACT_W = $bits(act_t);
endpackage

// File: rtl/tgu_cfg_regs.sv
// Configuration store: per step, four pattern words, four action words and
// one limit word. Decodes writes and presents the active step's settings.
// Assumes one write per cycle; the clear input has priority over a write.
module tgu_cfg_regs
    import tgu_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [STEP_W-1:0]              rd_step_i,
    output logic [GROUPS-1:0][SENSE_W-1:0] mask_o,
    output logic [GROUPS-1:0][SENSE_W-1:0] val_o,
    output act_t [GROUPS-1:0]              act_o,
    output logic [CNT_W-1:0]               cnt_lim_o,
    output logic [CNT_W-1:0]               tmr_cmp_o,
    output logic                           irq_clr_o
);
    logic [DATA_W-1:0] grp_q [STEPS][GROUPS];
    act_t              act_q [STEPS][GROUPS];
    logic [DATA_W-1:0] lim_q [STEPS];

    logic [SEL_W-1:0]  wsel;
    logic [STEP_W-1:0] wstep;

    assign wsel  = addr_i[SEL_W-1:0];
    assign wstep = addr_i[ADDR_W-1:SEL_W];

    // store writes into the addressed slot, wipe everything on reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int s = 0; s < STEPS; s++) begin
                for (int g = 0; g < GROUPS; g++) begin
                    grp_q[s][g] <= '0;
                    act_q[s][g] <= '0;
                end
                lim_q[s] <= '0;
            end
        end else if (we_i) begin
            for (int s = 0; s < STEPS; s++) begin
                if (wstep == STEP_W'(s)) begin
                    for (int g = 0; g < GROUPS; g++) begin
                        if (wsel == SEL_W'(g))
                            grp_q[s][g] <= wdata_i;
                        if (wsel == SEL_W'(SEL_ACT0 + g))
                            act_q[s][g] <= act_t'(wdata_i[ACT_W-1:0]);
                    end
                    if (wsel == SEL_W'(SEL_LIM))
                        lim_q[s] <= wdata_i;
                end
            end
        end
    end

    // present the active step's settings to the evaluator
    always_comb begin
        for (int g = 0; g < GROUPS; g++) begin
            mask_o[g] = grp_q[rd_step_i][g][DATA_W-1:SENSE_W];
            val_o[g]  = grp_q[rd_step_i][g][SENSE_W-1:0];
            act_o[g]  = act_q[rd_step_i][g];
        end
        tmr_cmp_o = lim_q[rd_step_i][DATA_W-1:CNT_W];
        cnt_lim_o = lim_q[rd_step_i][CNT_W-1:0];
    end

    assign irq_clr_o = we_i && (wsel == SEL_W'(SEL_IRQC));

    // R10: a clear leaves no armed or patterned setting behind
    p_clr_wipes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (act_o == '0 && mask_o == '0 && val_o == '0));
endmodule

// File: rtl/tgu_step_eval.sv
// Evaluates the four groups of the active step against the sense vector and
// the counter/timer state, and picks the highest-numbered satisfied group.
// Purely combinational; assumes settings of the active step are stable.
module tgu_step_eval
    import tgu_pkg::*;
(
    input  logic [SENSE_W-1:0]             sense_i,
    input  logic [GROUPS-1:0][SENSE_W-1:0] mask_i,
    input  logic [GROUPS-1:0][SENSE_W-1:0] val_i,
    input  act_t [GROUPS-1:0]              act_i,
    input  logic [CNT_W-1:0]               cnt_i,
    input  logic [CNT_W-1:0]               tmr_i,
    input  logic [CNT_W-1:0]               cnt_lim_i,
    input  logic [CNT_W-1:0]               tmr_cmp_i,
    output logic                           fire_o,
    output do_t                            do_o
);
    logic [GROUPS-1:0] hit;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic match;
        logic qual_ok;

        assign match = ((sense_i ^ val_i[g]) & mask_i[g]) == '0;

        // qualifier test against counter or timer
        always_comb begin
            case (act_i[g].c.qual)
                Q_ALWAYS: qual_ok = 1'b1;
                Q_CNT_GE: qual_ok = (cnt_i >= cnt_lim_i);
                Q_TMR_GE: qual_ok = (tmr_i >= tmr_cmp_i);
                default:  qual_ok = (cnt_i <  cnt_lim_i);
            endcase
        end

        assign hit[g] = act_i[g].c.arm && (!act_i[g].c.use_pat || match) && qual_ok;
    end

    // later (higher) groups override earlier ones
    always_comb begin
        fire_o = |hit;
        do_o   = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (hit[g])
                do_o = act_i[g].d;
        end
    end
endmodule

// File: rtl/tgu_seq_core.sv
// Sequencer state: active step, event counter, dwell timer, trigger pulse
// register and sticky interrupt. Applies the winning action at the clock edge.
// Assumes fire_i/do_i are derived from this cycle's state and sense inputs.
module tgu_seq_core
    import tgu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fire_i,
    input  do_t               do_i,
    input  logic              irq_clr_i,
    output logic [STEP_W-1:0] step_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  tmr_o,
    output logic [TRIG_W-1:0] trig_o,
    output logic              irq_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // step register: follow a jump, idle at step 0 when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)          step_o <= '0;
        else if (fire_i && do_i.jump) step_o <= do_i.next;
    end

    // event counter with saturation at both ends
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_o <= '0;
        end else if (fire_i) begin
            case (do_i.cnt_op)
                OP_INC:  if (cnt_o != CMAX) cnt_o <= cnt_o + 1'b1;
                OP_DEC:  if (cnt_o != '0)   cnt_o <= cnt_o - 1'b1;
                OP_ZERO: cnt_o <= '0;
                default: cnt_o <= cnt_o;
            endcase
        end
    end

    // dwell timer: restart on jump or clear action, else count up and saturate
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)                          tmr_o <= '0;
        else if (fire_i && (do_i.jump || do_i.tmr_clr)) tmr_o <= '0;
        else if (tmr_o != CMAX)                       tmr_o <= tmr_o + 1'b1;
    end

    // one-cycle trigger pulse after the acting edge
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) trig_o <= '0;
        else                 trig_o <= fire_i ? do_i.trig : '0;
    end

    // sticky interrupt: set by an action, cleared only by a write
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq_o <= 1'b0;
        else if (en_i && fire_i && do_i.irq) irq_o <= 1'b1;
        else if (irq_clr_i)                  irq_o <= 1'b0;
    end

    // R1: a disabled cycle leaves the sequencer idle
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (step_o == '0 && cnt_o == '0 && tmr_o == '0 && trig_o == '0));
    // R6: triggers only follow an acting cycle
    p_trig_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> (trig_o == '0));
    // R5: no action, no step change
    p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !fire_i) |=> $stable(step_o));
    // R7: no action, no counter change
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !fire_i) |=> $stable(cnt_o));
    // R7: decrement at zero does not wrap
    p_cnt_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && fire_i && do_i.cnt_op == OP_DEC && cnt_o == '0) |=> (cnt_o == '0));
    // R9: interrupt persists until a clearing write
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);
endmodule

// File: rtl/tgu_trigger_unit.sv
// Top of the step-sequenced trigger unit: configuration store, step evaluator
// and sequencer core. Assumes all inputs are synchronous to clk.
module tgu_trigger_unit
    import tgu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 cfg_clr_i,
    input  logic                 cfg_we_i,
    input  logic [ADDR_W-1:0]    cfg_addr_i,
    input  logic [DATA_W-1:0]    cfg_wdata_i,
    input  logic [SENSE_W-1:0]   sense_i,
    output logic [TRIG_W-1:0]    trig_o,
    output logic                 irq_o
);
    logic [STEP_W-1:0]              step;
    logic [CNT_W-1:0]               cnt;
    logic [CNT_W-1:0]               tmr;
    logic [GROUPS-1:0][SENSE_W-1:0] mask;
    logic [GROUPS-1:0][SENSE_W-1:0] val;
    act_t [GROUPS-1:0]              act;
    logic [CNT_W-1:0]               cnt_lim;
    logic [CNT_W-1:0]               tmr_cmp;
    logic                           irq_clr;
    logic                           fire;
    do_t                            win_do;

    tgu_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cfg_clr_i),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .rd_step_i (step),
        .mask_o    (mask),
        .val_o     (val),
        .act_o     (act),
        .cnt_lim_o (cnt_lim),
        .tmr_cmp_o (tmr_cmp),
        .irq_clr_o (irq_clr)
    );

    tgu_step_eval u_eval (
        .sense_i   (sense_i),
        .mask_i    (mask),
        .val_i     (val),
        .act_i     (act),
        .cnt_i     (cnt),
        .tmr_i     (tmr),
        .cnt_lim_i (cnt_lim),
        .tmr_cmp_i (tmr_cmp),
        .fire_o    (fire),
        .do_o      (win_do)
    );

    tgu_seq_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .fire_i    (fire),
        .do_i      (win_do),
        .irq_clr_i (irq_clr),
        .step_o    (step),
        .cnt_o     (cnt),
        .tmr_o     (tmr),
        .trig_o    (trig_o),
        .irq_o     (irq_o)
    );
endmodule

// File: tb/tgu_trigger_unit_tb.sv
// Scoreboard bench: the driver pushes expected {trig, irq} after each edge,
// the monitor pops and compares on the following falling edge.
module tgu_trigger_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_i;
    logic        cfg_clr_i;
    logic        cfg_we_i;
    logic [6:0]  cfg_addr_i;
    logic [31:0] cfg_wdata_i;
    logic [15:0] sense_i;
    logic [3:0]  trig_o;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    tgu_trigger_unit u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .cfg_clr_i(cfg_clr_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .sense_i(sense_i), .trig_o(trig_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] mk_act(input logic use_p, input logic [1:0] q,
                                           input logic tclr, input logic [1:0] op,
                                           input logic irq, input logic [3:0] trig,
                                           input logic jmp, input logic [2:0] nxt);
        return {16'h0, 1'b1, use_p, q, tclr, op, irq, trig, jmp, nxt};
    endfunction

    function automatic logic [6:0] adr(input int step, input int sub);
        return {3'(step), 4'(sub)};
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        en_i = 1'b0; cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        en_i = 1'b0; cfg_clr_i = 1'b1;
        @(negedge clk);
        cfg_clr_i = 1'b0;
    endtask

    // drive one cycle and queue the outputs expected after its edge
    task automatic cyc(input logic en, input logic [15:0] s,
                       input logic [3:0] etrig, input logic eirq, input string tag);
        @(negedge clk);
        en_i = en; sense_i = s;
        @(posedge clk);
        #1;
        exp_q.push_back({etrig, eirq});
        tag_q.push_back(tag);
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            logic [4:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if ({trig_o, irq_o} !== e) begin
                n_fail++;
                $display("FAIL %s: trig=%h irq=%b expected trig=%h irq=%b",
                         t, trig_o, irq_o, e[4:1], e[0]);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; en_i = 1'b0; cfg_clr_i = 1'b0; cfg_we_i = 1'b0;
        cfg_addr_i = '0; cfg_wdata_i = '0; sense_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 16'h0000, 4'h0, 1'b0, "R1 reset state");

        // R4: empty configuration never fires
        cyc(1'b1, 16'hFFFF, 4'h0, 1'b0, "R4 blank config");
        cyc(1'b1, 16'h0000, 4'h0, 1'b0, "R4 blank config");

        // R2/R11: masked pattern on step 0 group 0, continuous trigger
        wr(adr(0, 0), {16'h00F0, 16'hAA50});
        wr(adr(0, 4), mk_act(1, 0, 0, 0, 0, 4'h1, 0, 0));
        cyc(1'b1, 16'h1254, 4'h1, 1'b0, "R2 masked match");
        cyc(1'b1, 16'h1264, 4'h0, 1'b0, "R2 masked mismatch");
        cyc(1'b1, 16'hFF5F, 4'h1, 1'b0, "R2 bits outside mask ignored");

        // R3: priority among satisfied groups; R4 unarmed group 3
        wr(adr(0, 1), {16'h0001, 16'h0001});
        wr(adr(0, 5), mk_act(1, 0, 0, 0, 0, 4'h2, 0, 0));
        wr(adr(0, 2), {16'h0002, 16'h0002});
        wr(adr(0, 6), mk_act(1, 0, 0, 0, 0, 4'h4, 0, 0));
        wr(adr(0, 3), {16'h0008, 16'h0008});
        wr(adr(0, 7), 32'h0000_7080);
        cyc(1'b1, 16'h0053, 4'h4, 1'b0, "R3 group 2 beats 1 and 0");
        cyc(1'b1, 16'h0051, 4'h2, 1'b0, "R3 group 1 beats 0");
        cyc(1'b1, 16'h0050, 4'h1, 1'b0, "R3 group 0 alone");
        cyc(1'b1, 16'h0008, 4'h0, 1'b0, "R4 unarmed group ignored");

        // R10: clear wipes configuration
        clr();
        cyc(1'b1, 16'h0053, 4'h0, 1'b0, "R10 config cleared");

        // R5/R6/R1: two-step chain
        wr(adr(0, 0), {16'h0001, 16'h0001});
        wr(adr(0, 4), mk_act(1, 0, 0, 0, 0, 4'h0, 1, 1));
        wr(adr(1, 0), {16'h0002, 16'h0002});
        wr(adr(1, 4), mk_act(1, 0, 0, 0, 0, 4'h8, 1, 2));
        cyc(1'b1, 16'h0002, 4'h0, 1'b0, "R5 step 1 pattern ignored in step 0");
        cyc(1'b1, 16'h0001, 4'h0, 1'b0, "R5 jump to step 1");
        cyc(1'b1, 16'h0002, 4'h8, 1'b0, "R5 step 1 fires");
        cyc(1'b1, 16'h0002, 4'h0, 1'b0, "R6 single pulse, step 2 inert");
        cyc(1'b0, 16'h0000, 4'h0, 1'b0, "R1 disabled");
        cyc(1'b1, 16'h0002, 4'h0, 1'b0, "R1 restart at step 0");
        cyc(1'b1, 16'h0001, 4'h0, 1'b0, "R5 jump again");
        cyc(1'b1, 16'h0002, 4'h8, 1'b0, "R6 pulse after acting edge");

        // R7/R9: count to three, floor at zero, sticky interrupt
        clr();
        wr(adr(0, 0), {16'h0001, 16'h0001});
        wr(adr(0, 4), mk_act(1, 0, 0, 1, 0, 4'h0, 0, 0));
        wr(adr(0, 1), 32'h0);
        wr(adr(0, 5), mk_act(0, 1, 0, 3, 1, 4'h1, 0, 0));
        wr(adr(0, 2), {16'h0004, 16'h0004});
        wr(adr(0, 6), mk_act(1, 0, 0, 2, 0, 4'h0, 0, 0));
        wr(adr(0, 8), {16'hFFFF, 16'd3});
        cyc(1'b1, 16'h0004, 4'h0, 1'b0, "R7 decrement at zero");
        cyc(1'b1, 16'h0001, 4'h0, 1'b0, "R7 no wrap below zero");
        cyc(1'b1, 16'h0001, 4'h0, 1'b0, "R7 count 2");
        cyc(1'b1, 16'h0001, 4'h0, 1'b0, "R7 count 3");
        cyc(1'b1, 16'h0000, 4'h1, 1'b1, "R7 limit reached, R9 interrupt set");
        cyc(1'b1, 16'h0000, 4'h0, 1'b1, "R7 counter zeroed, R9 sticky");
        cyc(1'b0, 16'h0000, 4'h0, 1'b1, "R9 sticky while disabled");
        wr(adr(0, 15), 32'h0);
        cyc(1'b0, 16'h0000, 4'h0, 1'b0, "R9 cleared by write");

        // R8: timer expiry and restart on jump
        clr();
        wr(adr(0, 0), 32'h0);
        wr(adr(0, 4), mk_act(0, 2, 0, 0, 0, 4'h4, 1, 1));
        wr(adr(0, 8), {16'd5, 16'd0});
        wr(adr(1, 0), {16'h0001, 16'h0001});
        wr(adr(1, 4), mk_act(1, 0, 0, 0, 0, 4'h1, 1, 0));
        for (int i = 0; i < 5; i++) cyc(1'b1, 16'h0000, 4'h0, 1'b0, "R8 timer below compare");
        cyc(1'b1, 16'h0000, 4'h4, 1'b0, "R8 timer expiry");
        cyc(1'b1, 16'h0001, 4'h1, 1'b0, "R5 return to step 0");
        for (int i = 0; i < 5; i++) cyc(1'b1, 16'h0000, 4'h0, 1'b0, "R8 timer restarted");
        cyc(1'b1, 16'h0000, 4'h4, 1'b0, "R8 second expiry");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule